// File: doc/BRIEF.md
# Period-Match PWM Generator

This block produces a single pulse-width-modulated output from an 8-bit timebase. The timer runs on the clock divided by a selectable prescale of 1, 4 or 16. Every prescaled step is cut into four sub-steps by a 2-bit sub-count. The timer is compared with a period register. When the last sub-step of the count equal to the period ends, a period match occurs and the timer starts again from zero. The 8-bit timer joined with the 2-bit sub-count forms a 10-bit extended count. That count is compared with a 10-bit duty value, so one clock period (times the prescale) is the resolution of the on-time.

Software sets the block up through a small write-only register port. The duty value takes effect only at a period boundary, because the block copies it into a shadow register at each match. Each match also advances a postscaler, and every Nth match (N = 1..16) raises a one-cycle interrupt pulse. A waveform state machine drives the output. Its states are WV_OFF (mode code not enabled), WV_ARM (enabled, waiting for the first match), WV_HIGH and WV_LOW. Its transitions are:
- WV_OFF to WV_ARM once the mode code reads 1100.
- Any state to WV_OFF when the mode code reads anything else.
- WV_ARM, WV_HIGH or WV_LOW to WV_HIGH at a match when the new shadow duty is non-zero, and to WV_LOW at a match when it is zero.
- WV_HIGH to WV_LOW when the extended count reaches the shadow duty.

Register map, selected by `wr_addr`:
- 0: period value.
- 1: duty bits 9:2.
- 2: waveform control. Bits 3:0 hold the mode code and bits 5:4 hold duty bits 1:0.
- 3: timer control. Bits 1:0 select the prescale (00 gives 1, 01 gives 4, 10 and 11 give 16), bit 2 is timer-on, and bits 6:3 hold the postscale count minus one.
- 4: timer count. A write loads the count.

Top module: `pwm_tmr_core`

## Requirements
- R1: After reset all registers are zero, the timer is stopped, and `pwm_out` and `irq_pulse` are low until software configures the block.
- R2: With timer-on set, the output period is (P+1)·4·S clock cycles, where P is the period register and S is the prescale selected by timer-control bits 1:0 (00→1, 01→4, 10→16, 11→16).
- R3: The output is high for D·S clock cycles of each period, where D = {duty register, waveform-control bits 5:4}, for 0 < D < 4·(P+1).
- R4: A duty value of 0 keeps `pwm_out` low every cycle, with no pulse at the period boundary.
- R5: A duty value of at least 4·(P+1) keeps `pwm_out` high for the whole period, with no low cycle.
- R6: `pwm_out` is low whenever waveform-control bits 3:0 differ from 1100.
- R7: A duty write takes effect only at the next period match. The period in progress keeps its old on-time.
- R8: `irq_pulse` is high for exactly one cycle on every Nth period match, where N is timer-control bits 6:3 plus one. It is asserted on the same edge at which `pwm_out` rises for that period.
- R9: While timer-on is clear, the timer, `pwm_out` and the postscaler hold still and no `irq_pulse` occurs.
- R10: A write of value V to the timer count loads the timer with V and clears the prescale, sub-count and postscale counts. The next match follows (P−V+1)·4·S cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM waveform |
| irq_pulse | output | 1 | Postscaled period-match pulse |

## Verification
A register write lands on the rising edge that samples `wr_en`. A write to the timer count restarts the sub-step counting on that same edge. The output and the interrupt are both registered, so both change on the match edge itself, and a new duty value first shows in the period that begins at the next match. The scoreboard therefore measures on-time and period from one observed rising edge of `pwm_out` to the next, and it takes no measurement until two full periods after a reconfiguration. Checks that depend on a fixed latency, such as a timer load, the instant of the duty change and the interrupt spacing, count falling clock edges from the write that caused them. They sample exactly at the predicted cycle and at the cycle before it.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    // Mode code that enables waveform generation
    localparam logic [3:0] WAVE_ENABLE_CODE = 4'b1100;

    // Register select values
    localparam int ADR_PERIOD   = 0;
    localparam int ADR_DUTY_HI  = 1;
    localparam int ADR_WAVE_CTL = 2;
    localparam int ADR_TMR_CTL  = 3;
    localparam int ADR_TMR_CNT  = 4;

    typedef enum logic [1:0] {
        WV_OFF,
        WV_ARM,
        WV_HIGH,
        WV_LOW
    } wave_state_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV4   = 2'b01,
        PS_DIV16A = 2'b10,
        PS_DIV16B = 2'b11
    } psc_sel_e;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int SUB_W  = 2,
    parameter int POST_W = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    output logic [TMR_W-1:0]  period_q,
    output logic [TMR_W-1:0]  duty_hi_q,
    output logic [SUB_W-1:0]  duty_lo_q,
    output logic [3:0]        mode_q,
    output psc_sel_e          psc_sel_q,
    output logic              tmr_on_q,
    output logic [POST_W-1:0] post_sel_q,
    output logic              tmr_wr,
    output logic [TMR_W-1:0]  tmr_wdata
);

    localparam int LO_LSB   = 4;
    localparam int ON_BIT   = 2;
    localparam int POST_LSB = 3;

    logic sel_period, sel_duty, sel_wave, sel_tctl, sel_tcnt;

    always_comb begin
        sel_period = wr_en && (wr_addr == ADDR_W'(ADR_PERIOD));
        sel_duty   = wr_en && (wr_addr == ADDR_W'(ADR_DUTY_HI));
        sel_wave   = wr_en && (wr_addr == ADDR_W'(ADR_WAVE_CTL));
        sel_tctl   = wr_en && (wr_addr == ADDR_W'(ADR_TMR_CTL));
        sel_tcnt   = wr_en && (wr_addr == ADDR_W'(ADR_TMR_CNT));
    end

    // Timer load is passed straight through so it acts on the write edge
    assign tmr_wr    = sel_tcnt;
    assign tmr_wdata = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q   <= '0;
            duty_hi_q  <= '0;
            duty_lo_q  <= '0;
            mode_q     <= '0;
            psc_sel_q  <= PS_DIV1;
            tmr_on_q   <= 1'b0;
            post_sel_q <= '0;
        end else begin
            if (sel_period) begin
                period_q <= wr_data;
            end
            if (sel_duty) begin
                duty_hi_q <= wr_data;
            end
            if (sel_wave) begin
                mode_q    <= wr_data[3:0];
                duty_lo_q <= wr_data[LO_LSB +: SUB_W];
            end
            if (sel_tctl) begin
                psc_sel_q  <= psc_sel_e'(wr_data[1:0]);
                tmr_on_q   <= wr_data[ON_BIT];
                post_sel_q <= wr_data[POST_LSB +: POST_W];
            end
        end
    end

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^wr_data[TMR_W-1:POST_LSB+POST_W];

endmodule

// File: rtl/pwm_tmr_timebase.sv
module pwm_tmr_timebase
    import pwm_tmr_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2,
    parameter int PSC_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tmr_on,
    input  psc_sel_e               psc_sel,
    input  logic [TMR_W-1:0]       period,
    input  logic                   tmr_wr,
    input  logic [TMR_W-1:0]       tmr_wdata,
    output logic [TMR_W+SUB_W-1:0] ext_cnt,
    output logic                   step_end,
    output logic                   match,
    output logic [TMR_W-1:0]       tmr_q
);

    localparam int MID_DIV = 4;

    logic [PSC_W-1:0] psc_q;
    logic [SUB_W-1:0] sub_q;
    logic [PSC_W-1:0] psc_lim;
    logic             tick;

    // Prescale limit (divide minus one) per select code
    always_comb begin
        unique case (psc_sel)
            PS_DIV1:   psc_lim = '0;
            PS_DIV4:   psc_lim = PSC_W'(MID_DIV - 1);
            PS_DIV16A: psc_lim = '1;
            PS_DIV16B: psc_lim = '1;
            default:   psc_lim = '1;
        endcase
    end

    always_comb begin
        step_end = tmr_on && !tmr_wr && (psc_q >= psc_lim);
        tick     = step_end && (sub_q == '1);
        match    = tick && (tmr_q == period);
        ext_cnt  = {tmr_q, sub_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
            sub_q <= '0;
            tmr_q <= '0;
        end else if (tmr_wr) begin
            psc_q <= '0;
            sub_q <= '0;
            tmr_q <= tmr_wdata;
        end else if (tmr_on) begin
            if (step_end) begin
                psc_q <= '0;
                sub_q <= sub_q + SUB_W'(1);
                if (tick) begin
                    tmr_q <= match ? '0 : tmr_q + TMR_W'(1);
                end
            end else begin
                psc_q <= psc_q + PSC_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_tmr_postscale.sv
module pwm_tmr_postscale #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match,
    input  logic              clr,
    input  logic [POST_W-1:0] post_sel,
    output logic              irq_pulse
);

    logic [POST_W-1:0] cnt_q;
    logic              fire;

    always_comb begin
        fire = match && !clr && (cnt_q >= post_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= fire;
            if (clr) begin
                cnt_q <= '0;
            end else if (match) begin
                cnt_q <= fire ? '0 : cnt_q + POST_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave
    import pwm_tmr_pkg::*;
#(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ok,
    input  logic              match,
    input  logic              step_end,
    input  logic [DUTY_W-1:0] ext_cnt,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [DUTY_W-1:0] duty_shadow,
    output logic              pwm_out
);

    localparam int EXT_W = DUTY_W + 1;

    wave_state_e state_q, state_d;
    logic        hit;
    logic        next_on;

    // Shadow duty is refreshed only at a period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_shadow <= '0;
        end else if (match) begin
            duty_shadow <= duty_in;
        end
    end

    always_comb begin
        hit     = step_end &&
                  (({1'b0, ext_cnt} + EXT_W'(1)) == {1'b0, duty_shadow});
        next_on = (duty_in != '0);
    end

    always_comb begin
        state_d = state_q;
        if (!mode_ok) begin
            state_d = WV_OFF;
        end else begin
            unique case (state_q)
                WV_OFF: begin
                    state_d = WV_ARM;
                end
                WV_ARM: begin
                    if (match) state_d = next_on ? WV_HIGH : WV_LOW;
                end
                WV_HIGH: begin
                    if (match)    state_d = next_on ? WV_HIGH : WV_LOW;
                    else if (hit) state_d = WV_LOW;
                end
                WV_LOW: begin
                    if (match) state_d = next_on ? WV_HIGH : WV_LOW;
                end
                default: state_d = WV_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WV_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pwm_out = (state_q == WV_HIGH);
    end

endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
    import pwm_tmr_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int SUB_W  = 2,
    parameter int PSC_W  = 4,
    parameter int POST_W = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TMR_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic              irq_pulse
);

    localparam int DUTY_W = TMR_W + SUB_W;

    logic [TMR_W-1:0]  period_q;
    logic [TMR_W-1:0]  duty_hi_q;
    logic [SUB_W-1:0]  duty_lo_q;
    logic [3:0]        mode_q;
    psc_sel_e          psc_sel_q;
    logic              tmr_on_q;
    logic [POST_W-1:0] post_sel_q;
    logic              tmr_wr;
    logic [TMR_W-1:0]  tmr_wdata;
    logic [DUTY_W-1:0] ext_cnt;
    logic              step_end;
    logic              match;
    logic [TMR_W-1:0]  tmr_q;
    logic [DUTY_W-1:0] duty_shadow;
    logic              mode_ok;

    assign mode_ok = (mode_q == WAVE_ENABLE_CODE);

    pwm_tmr_regs #(
        .TMR_W (TMR_W),
        .SUB_W (SUB_W),
        .POST_W(POST_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .period_q  (period_q),
        .duty_hi_q (duty_hi_q),
        .duty_lo_q (duty_lo_q),
        .mode_q    (mode_q),
        .psc_sel_q (psc_sel_q),
        .tmr_on_q  (tmr_on_q),
        .post_sel_q(post_sel_q),
        .tmr_wr    (tmr_wr),
        .tmr_wdata (tmr_wdata)
    );

    pwm_tmr_timebase #(
        .TMR_W(TMR_W),
        .SUB_W(SUB_W),
        .PSC_W(PSC_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_on   (tmr_on_q),
        .psc_sel  (psc_sel_q),
        .period   (period_q),
        .tmr_wr   (tmr_wr),
        .tmr_wdata(tmr_wdata),
        .ext_cnt  (ext_cnt),
        .step_end (step_end),
        .match    (match),
        .tmr_q    (tmr_q)
    );

    pwm_tmr_postscale #(
        .POST_W(POST_W)
    ) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .clr      (tmr_wr),
        .post_sel (post_sel_q),
        .irq_pulse(irq_pulse)
    );

    pwm_tmr_wave #(
        .DUTY_W(DUTY_W)
    ) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_ok    (mode_ok),
        .match      (match),
        .step_end   (step_end),
        .ext_cnt    (ext_cnt),
        .duty_in    ({duty_hi_q, duty_lo_q}),
        .duty_shadow(duty_shadow),
        .pwm_out    (pwm_out)
    );

endmodule

// File: rtl/pwm_tmr_core_chk.sv
module pwm_tmr_core_chk #(
    parameter int TMR_W  = 8,
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_out,
    input logic              irq_pulse,
    input logic              match,
    input logic              tmr_on_q,
    input logic              tmr_wr,
    input logic [TMR_W-1:0]  tmr_q,
    input logic [DUTY_W-1:0] duty_shadow,
    input logic [3:0]        mode_q
);

    a_r6_mode_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 4'b1100) |=> !pwm_out)
        else $error("R6 output high with mode disabled");

    a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((duty_shadow == '0) && !match) |=> !pwm_out)
        else $error("R4 output high with zero duty");

    a_r7_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(duty_shadow))
        else $error("R7 shadow duty changed outside a match");

    a_r8_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse)
        else $error("R8 interrupt pulse longer than one cycle");

    a_r8_irq_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(match))
        else $error("R8 interrupt without a period match");

    a_r9_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_on_q && !tmr_wr) |=> $stable(tmr_q))
        else $error("R9 timer moved while stopped");

    a_r9_no_irq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_on_q |=> !irq_pulse)
        else $error("R9 interrupt while timer stopped");

endmodule

bind pwm_tmr_core pwm_tmr_core_chk #(
    .TMR_W (TMR_W),
    .DUTY_W(DUTY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .irq_pulse  (irq_pulse),
    .match      (match),
    .tmr_on_q   (tmr_on_q),
    .tmr_wr     (tmr_wr),
    .tmr_q      (tmr_q),
    .duty_shadow(duty_shadow),
    .mode_q     (mode_q)
);

// File: tb/pwm_tmr_core_tb.sv
module pwm_tmr_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out;
    logic       irq_pulse;

    always #5 clk = ~clk;

    pwm_tmr_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm_out  (pwm_out),
        .irq_pulse(irq_pulse)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int    hi;
        int    per;
        string req;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: measures on-time and period between rising edges
    int   cyc = 0;
    logic prev_pwm = 1'b0;
    int   start_c = 0;
    int   hi_c = 0;
    bit   have_start = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (pwm_out && !prev_pwm) begin
            if (have_start && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(hi_c == e.hi, e.req, "on-time", hi_c, e.hi);
                chk((cyc - start_c) == e.per, e.req, "period", cyc - start_c, e.per);
            end
            have_start = (exp_q.size() > 0);
            start_c = cyc;
            hi_c = 0;
        end
        if (pwm_out) hi_c++;
        prev_pwm = pwm_out;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [7:0] pr, input logic [1:0] sel,
                         input logic [3:0] post, input logic [9:0] duty,
                         input logic [3:0] mode);
        wr(3'd0, pr);
        wr(3'd1, duty[9:2]);
        wr(3'd2, {2'b00, duty[1:0], mode});
        wr(3'd3, {1'b0, post, 1'b1, sel});
        wr(3'd4, 8'd0);
    endtask

    task automatic expect_run(input int hi, input int per, input int n,
                              input string req);
        int guard;
        repeat (2 * per + 8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.hi = hi;
            e.per = per;
            e.req = req;
            exp_q.push_back(e);
        end
        guard = 0;
        while (exp_q.size() > 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, req, "periods left unmeasured", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic count_level(input int n, input logic lvl, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out == lvl) cnt++;
        end
    endtask

    task automatic wait_rise();
        int g;
        g = 0;
        while (pwm_out && g < 5000) begin @(negedge clk); g++; end
        while (!pwm_out && g < 10000) begin @(negedge clk); g++; end
    endtask

    task automatic irq_gap(input int expv, input string req);
        int g;
        int k;
        logic pv;
        g = 0;
        pv = pwm_out;
        while (!irq_pulse && g < 5000) begin
            pv = pwm_out;
            @(negedge clk);
            g++;
        end
        chk(pwm_out == 1'b1 && pv == 1'b0, req, "output rises with interrupt",
            {pv, pwm_out}, 1);
        @(negedge clk);
        chk(irq_pulse == 1'b0, req, "pulse width", irq_pulse, 0);
        k = 1;
        while (!irq_pulse && k < 5000) begin @(negedge clk); k++; end
        chk(k == expv, req, "interrupt spacing", k, expv);
    endtask

    initial begin
        int cnt;
        int chg;
        int irqs;
        logic lv;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pwm_out == 1'b0, "R1", "pwm in reset", pwm_out, 0);
        chk(irq_pulse == 1'b0, "R1", "irq in reset", irq_pulse, 0);
        rst_n = 1'b1;
        irqs = 0;
        cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pwm_out) cnt++;
            if (irq_pulse) irqs++;
        end
        chk(cnt == 0, "R1", "pwm high cycles after reset", cnt, 0);
        chk(irqs == 0, "R1", "irq after reset", irqs, 0);

        // R2/R3: three prescale settings and sub-step resolution
        setup(8'd9, 2'b00, 4'd0, 10'd17, 4'b1100);
        expect_run(17, 40, 3, "R3");
        setup(8'd4, 2'b01, 4'd0, 10'd6, 4'b1100);
        expect_run(24, 80, 2, "R2");
        setup(8'd2, 2'b10, 4'd0, 10'd5, 4'b1100);
        expect_run(80, 192, 2, "R2");
        setup(8'd1, 2'b11, 4'd0, 10'd3, 4'b1100);
        expect_run(48, 128, 2, "R2");
        setup(8'd3, 2'b00, 4'd0, 10'd1, 4'b1100);
        expect_run(1, 16, 3, "R3");
        setup(8'd5, 2'b00, 4'd0, 10'd23, 4'b1100);
        expect_run(23, 24, 3, "R3");

        // R5: duty equal to full period length
        setup(8'd5, 2'b00, 4'd0, 10'd24, 4'b1100);
        repeat (60) @(negedge clk);
        count_level(120, 1'b0, cnt);
        chk(cnt == 0, "R5", "low cycles at full duty", cnt, 0);

        // R4: zero duty
        setup(8'd3, 2'b00, 4'd0, 10'd0, 4'b1100);
        repeat (40) @(negedge clk);
        count_level(120, 1'b1, cnt);
        chk(cnt == 0, "R4", "high cycles at zero duty", cnt, 0);

        // R6: wrong mode code, then correct code restores output
        setup(8'd9, 2'b00, 4'd0, 10'd17, 4'b1101);
        count_level(200, 1'b1, cnt);
        chk(cnt == 0, "R6", "high cycles with mode 1101", cnt, 0);
        wr(3'd2, {2'b00, 2'b01, 4'b1100});
        expect_run(17, 40, 2, "R6");

        // R7: duty change mid-period does not alter current on-time
        wait_rise();
        repeat (3) @(negedge clk);
        wr(3'd1, 8'd7);
        wr(3'd2, {2'b00, 2'b10, 4'b1100});
        repeat (9) @(negedge clk);
        chk(pwm_out == 1'b1, "R7", "old duty still high at cycle 16", pwm_out, 1);
        repeat (4) @(negedge clk);
        chk(pwm_out == 1'b0, "R7", "old duty low at cycle 20", pwm_out, 0);
        expect_run(30, 40, 2, "R7");

        // R8: interrupt each match, then every third match
        setup(8'd3, 2'b00, 4'd0, 10'd5, 4'b1100);
        repeat (40) @(negedge clk);
        irq_gap(16, "R8");
        setup(8'd3, 2'b00, 4'd2, 10'd5, 4'b1100);
        repeat (40) @(negedge clk);
        irq_gap(48, "R8");

        // R9: timer stopped freezes output and interrupt
        wr(3'd3, {1'b0, 4'd0, 1'b0, 2'b00});
        repeat (2) @(negedge clk);
        lv = pwm_out;
        chg = 0;
        irqs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pwm_out != lv) chg++;
            if (irq_pulse) irqs++;
        end
        chk(chg == 0, "R9", "output changes while stopped", chg, 0);
        chk(irqs == 0, "R9", "interrupts while stopped", irqs, 0);

        // R10: timer load restarts counts and postscaler
        setup(8'd9, 2'b00, 4'd2, 10'd2, 4'b1100);
        repeat (100) @(negedge clk);
        wait_rise();
        repeat (10) @(negedge clk);
        wr(3'd4, 8'd5);
        repeat (19) @(negedge clk);
        chk(pwm_out == 1'b0, "R10", "pwm one cycle before match", pwm_out, 0);
        @(negedge clk);
        chk(pwm_out == 1'b1, "R10", "pwm at predicted match", pwm_out, 1);
        chk(irq_pulse == 1'b0, "R10", "irq at first match after load", irq_pulse, 0);
        repeat (79) @(negedge clk);
        chk(irq_pulse == 1'b0, "R10", "irq one cycle before third match", irq_pulse, 0);
        @(negedge clk);
        chk(irq_pulse == 1'b1, "R10", "irq at third match after load", irq_pulse, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule